// File: doc/BRIEF.md
# Serial Adapter Control and Status Unit

This unit is the register front end of a small asynchronous serial adapter. A processor reaches it over a narrow bus made of a chip select, a read/write line and one register-select line. A write to the control register sets three things: the clock divide ratio, one of eight fixed character formats, and how the request-to-send line, the break and the transmit interrupt behave. One divisor code does not set a ratio. It puts the adapter into master reset, where the datapath is held idle. A read of the status register returns flags gathered from the receive and transmit paths and from the two modem inputs. An active-low interrupt line combines the enabled sources.

The shifters are not part of this unit. The receive side delivers a finished character on a one-cycle load strobe, together with its parity and framing error indications. The transmit side takes the buffered byte on a one-cycle take strobe. The decoded format and divide ratio leave the unit as plain outputs for those shifters to use.

Top module: `acia_ctrl_stat`

## Requirements
- R1: Control bits [1:0] set the divide ratio output: 00 gives 1, 01 gives DIV_MID (default 16), 10 gives DIV_HI (default 64).
- R2: Control bits [1:0] = 11 is master reset, and the control register resets to 0x03. While in master reset: dp_idle is 1, irq_n is high, status bits 0, 1, 4, 5, 6 and 7 read 0, and receive loads and data-register writes are ignored. Pending flags are flushed. The unit leaves master reset on the next control write whose bits [1:0] are not 11.
- R3: Control bits [4:2] select the format as {len8, stop2, par_en, par_odd}: 000 → 0110, 001 → 0111, 010 → 0010, 011 → 0011, 100 → 1100, 101 → 1000, 110 → 1010, 111 → 1011.
- R4: Control bits [6:5] set the handshake: 00 drives rts_line 0 with the transmit interrupt off; 01 drives rts_line 0 with the transmit interrupt on; 10 drives rts_line 1 with the transmit interrupt off; 11 drives rts_line 0 and brk_out 1 with the transmit interrupt off (brk_out is 0 in master reset).
- R5: Control bit 7 enables the receive interrupt.
- R6: A status read (rs=0, rw=1) returns bit 0 receive full, bit 1 transmit empty, bit 2 carrier line (dcd_line), bit 3 clear-to-send line (cts_line), bit 4 framing error, bit 5 overrun, bit 6 parity error, bit 7 interrupt pending.
- R7: A receive load sets receive full and captures the character and its framing error. The parity error is captured only if the current format has parity. A data read (rs=1, rw=1) returns the character, and from the next cycle receive full, parity, framing and overrun read 0.
- R8: A receive load that arrives while receive full is set, with no data read in the same cycle, sets overrun and keeps the old character.
- R9: While cts_line is 1, status bit 1 reads 0.
- R10: The interrupt is pending when the receive interrupt is enabled and any of receive full, overrun or dcd_line is 1. It is also pending when the transmit interrupt is enabled and status bit 1 is 1. Status bit 7 equals the pending condition, and irq_n is its inverse.
- R11: A data write (rs=1, rw=0) fills the transmit buffer (tx_pending 1, tx_data = written byte, status bit 1 = 0). A tx_take empties it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 1 | 0 = control/status, 1 = data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is selected |
| irq_n | output | 1 | Active-low interrupt request |
| rx_load | input | 1 | Receive shifter delivers a character |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error of the delivered character |
| rx_ferr | input | 1 | Framing error of the delivered character |
| tx_take | input | 1 | Transmit shifter takes the buffered byte |
| tx_pending | output | 1 | Transmit buffer holds a byte |
| tx_data | output | 8 | Buffered transmit byte |
| cts_line | input | 1 | Clear-to-send line, high = not clear |
| dcd_line | input | 1 | Carrier line, high = carrier lost |
| rts_line | output | 1 | Request-to-send line level |
| brk_out | output | 1 | Continuous break request |
| dp_idle | output | 1 | Datapath held idle (master reset) |
| div_ratio | output | 7 | Clock divide ratio, 0 in master reset |
| fmt_len8 | output | 1 | 1 = 8 data bits, 0 = 7 |
| fmt_stop2 | output | 1 | 1 = two stop bits |
| fmt_par_en | output | 1 | Parity enabled |
| fmt_par_odd | output | 1 | Odd parity |

## Verification
The bench builds the unit with its default divide ratios of 16 and 64. With those values, all three non-reset divisor codes give ratios the bench can tell apart, and each code of the eight-entry format and handshake table can be paired with a distinct divisor. The receive-error sequences run under two formats, one with parity and one without. This shows that the parity indication is gated while the framing indication is not, and it exercises overrun and interrupt masking on the same held character.

// File: rtl/acia_pkg.sv
package acia_pkg;
    localparam int BW = 8;

    typedef enum logic [1:0] {
        HS_LOW_QUIET  = 2'b00,
        HS_LOW_TXIRQ  = 2'b01,
        HS_HIGH_QUIET = 2'b10,
        HS_BREAK      = 2'b11
    } hs_mode_e;

    typedef struct packed {
        logic len8;
        logic stop2;
        logic par_en;
        logic par_odd;
    } fmt_t;

    typedef struct packed {
        logic          rdrf;
        logic          ovrn;
        logic          perr;
        logic          ferr;
        logic          tx_full;
        logic [BW-1:0] rx_byte;
        logic [BW-1:0] tx_byte;
    } flags_t;
endpackage

// File: rtl/acia_fmt_dec.sv
module acia_fmt_dec
    import acia_pkg::*;
(
    input  logic [2:0] code,
    output fmt_t       fmt
);
    always_comb begin
        fmt.len8    = code[2];
        // eight-bit words take two stops only with the no-parity code 100
        fmt.stop2   = code[2] ? (code[1:0] == 2'b00) : ~code[1];
        fmt.par_en  = ~code[2] | code[1];
        fmt.par_odd = fmt.par_en & code[0];
    end
endmodule

// File: rtl/acia_mode_dec.sv
module acia_mode_dec
    import acia_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64,
    localparam int DIV_W  = $clog2(DIV_HI + 1)
) (
    input  logic [1:0]       div_code,
    input  logic [1:0]       hs_code,
    output logic [DIV_W-1:0] ratio,
    output logic             mr,
    output logic             rts_line,
    output logic             brk,
    output logic             tie
);
    hs_mode_e hs;

    always_comb begin
        hs = hs_mode_e'(hs_code);
        mr = 1'b0;
        unique case (div_code)
            2'b00:   ratio = DIV_W'(1);
            2'b01:   ratio = DIV_W'(DIV_MID);
            2'b10:   ratio = DIV_W'(DIV_HI);
            default: begin
                ratio = '0;
                mr    = 1'b1;
            end
        endcase
        rts_line = (hs == HS_HIGH_QUIET);
        tie      = (hs == HS_LOW_TXIRQ);
        brk      = (hs == HS_BREAK) && !mr;
    end
endmodule

// File: rtl/acia_irq_gen.sv
module acia_irq_gen (
    input  logic mr,
    input  logic rie,
    input  logic tie,
    input  logic rdrf,
    input  logic ovrn,
    input  logic dcd,
    input  logic tdre_vis,
    output logic irq
);
    logic rx_src, tx_src;

    always_comb begin
        rx_src = rie && (rdrf || ovrn || dcd);
        tx_src = tie && tdre_vis;
        irq    = !mr && (rx_src || tx_src);
    end
endmodule

// File: rtl/acia_flags.sv
module acia_flags
    import acia_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mr,
    input  logic          rd_data,
    input  logic          wr_data,
    input  logic [BW-1:0] wbyte,
    input  logic          rx_load,
    input  logic [BW-1:0] rx_char,
    input  logic          rx_perr,
    input  logic          rx_ferr,
    input  logic          par_en,
    input  logic          tx_take,
    output flags_t        flags_q
);
    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (rd_data) begin
            flags_d.rdrf = 1'b0;
            flags_d.ovrn = 1'b0;
            flags_d.perr = 1'b0;
            flags_d.ferr = 1'b0;
        end
        if (rx_load) begin
            if (flags_q.rdrf && !rd_data) begin
                flags_d.ovrn = 1'b1;
            end else begin
                flags_d.rdrf    = 1'b1;
                flags_d.rx_byte = rx_char;
                flags_d.perr    = rx_perr && par_en;
                flags_d.ferr    = rx_ferr;
            end
        end
        if (tx_take) flags_d.tx_full = 1'b0;
        if (wr_data) begin
            flags_d.tx_full = 1'b1;
            flags_d.tx_byte = wbyte;
        end
        if (mr) begin
            flags_d.rdrf    = 1'b0;
            flags_d.ovrn    = 1'b0;
            flags_d.perr    = 1'b0;
            flags_d.ferr    = 1'b0;
            flags_d.tx_full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !rx_load |=> !flags_q.rdrf && !flags_q.ovrn && !flags_q.perr && !flags_q.ferr);

    a_r7_parity_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load && !par_en && !mr && (!flags_q.rdrf || rd_data) |=> !flags_q.perr);

    a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load && flags_q.rdrf && !rd_data && !mr |=> flags_q.ovrn && $stable(flags_q.rx_byte));

    a_r2_mr_flush: assert property (@(posedge clk) disable iff (!rst_n)
        mr |=> !flags_q.rdrf && !flags_q.tx_full && !flags_q.ovrn);

    a_r11_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && !mr |=> flags_q.tx_full && flags_q.tx_byte == $past(wbyte));
endmodule

// File: rtl/acia_ctrl_stat.sv
module acia_ctrl_stat
    import acia_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64,
    localparam int DIV_W  = $clog2(DIV_HI + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             rw,
    input  logic             rs,
    input  logic [BW-1:0]    wdata,
    output logic [BW-1:0]    rdata,
    output logic             irq_n,
    input  logic             rx_load,
    input  logic [BW-1:0]    rx_char,
    input  logic             rx_perr,
    input  logic             rx_ferr,
    input  logic             tx_take,
    output logic             tx_pending,
    output logic [BW-1:0]    tx_data,
    input  logic             cts_line,
    input  logic             dcd_line,
    output logic             rts_line,
    output logic             brk_out,
    output logic             dp_idle,
    output logic [DIV_W-1:0] div_ratio,
    output logic             fmt_len8,
    output logic             fmt_stop2,
    output logic             fmt_par_en,
    output logic             fmt_par_odd
);
    localparam logic [BW-1:0] CTRL_RST = 8'h03;

    logic [BW-1:0] ctrl_d, ctrl_q;
    logic          ctrl_wr, data_wr, data_rd;
    logic          mr, tie, irq, tdre_vis;
    logic [BW-1:0] status;
    fmt_t          fmt;
    flags_t        flags_q;

    always_comb begin
        ctrl_wr = cs && !rw && !rs;
        ctrl_d  = ctrl_wr ? wdata : ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

    acia_mode_dec #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) i_mode (
        .div_code (ctrl_q[1:0]),
        .hs_code  (ctrl_q[6:5]),
        .ratio    (div_ratio),
        .mr       (mr),
        .rts_line (rts_line),
        .brk      (brk_out),
        .tie      (tie)
    );

    acia_fmt_dec i_fmt (
        .code (ctrl_q[4:2]),
        .fmt  (fmt)
    );

    always_comb begin
        data_wr = cs && !rw && rs && !mr;
        data_rd = cs && rw && rs;
    end

    acia_flags i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .mr      (mr),
        .rd_data (data_rd),
        .wr_data (data_wr),
        .wbyte   (wdata),
        .rx_load (rx_load),
        .rx_char (rx_char),
        .rx_perr (rx_perr),
        .rx_ferr (rx_ferr),
        .par_en  (fmt.par_en),
        .tx_take (tx_take),
        .flags_q (flags_q)
    );

    always_comb tdre_vis = !flags_q.tx_full && !cts_line && !mr;

    acia_irq_gen i_irq (
        .mr       (mr),
        .rie      (ctrl_q[7]),
        .tie      (tie),
        .rdrf     (flags_q.rdrf),
        .ovrn     (flags_q.ovrn),
        .dcd      (dcd_line),
        .tdre_vis (tdre_vis),
        .irq      (irq)
    );

    always_comb begin
        status = {irq,
                  flags_q.perr && !mr,
                  flags_q.ovrn && !mr,
                  flags_q.ferr && !mr,
                  cts_line,
                  dcd_line,
                  tdre_vis,
                  flags_q.rdrf && !mr};
        if (cs && rw) rdata = rs ? flags_q.rx_byte : status;
        else          rdata = '0;
        irq_n       = !irq;
        dp_idle     = mr;
        tx_pending  = flags_q.tx_full;
        tx_data     = flags_q.tx_byte;
        fmt_len8    = fmt.len8;
        fmt_stop2   = fmt.stop2;
        fmt_par_en  = fmt.par_en;
        fmt_par_odd = fmt.par_odd;
    end

    a_r9_cts_hides_empty: assert property (@(posedge clk) disable iff (!rst_n)
        cts_line |-> !status[1]);

    a_r2_mr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dp_idle |-> irq_n && !brk_out);

    a_r4_break_rts_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_out |-> !rts_line);

    a_r10_rx_source: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[7] && !dp_idle && flags_q.rdrf |-> !irq_n);
endmodule

// File: tb/test_acia_ctrl_stat.sv
module test_acia_ctrl_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 0, rw = 1, rs = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       irq_n;
    logic       rx_load = 0, rx_perr = 0, rx_ferr = 0, tx_take = 0;
    logic [7:0] rx_char = 0;
    logic       tx_pending;
    logic [7:0] tx_data;
    logic       cts_line = 0, dcd_line = 0;
    logic       rts_line, brk_out, dp_idle;
    logic [6:0] div_ratio;
    logic       fmt_len8, fmt_stop2, fmt_par_en, fmt_par_odd;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    acia_ctrl_stat i_acia_ctrl_stat (.*);

    // {ctrl, fmt{len8,stop2,par_en,par_odd}, div, rts, brk, irq}
    localparam logic [21:0] VEC [8] = '{
        {8'h00, 4'b0110, 7'd1,  1'b0, 1'b0, 1'b0},
        {8'h25, 4'b0111, 7'd16, 1'b0, 1'b0, 1'b1},
        {8'h4A, 4'b0010, 7'd64, 1'b1, 1'b0, 1'b0},
        {8'h6C, 4'b0011, 7'd1,  1'b0, 1'b1, 1'b0},
        {8'h11, 4'b1100, 7'd16, 1'b0, 1'b0, 1'b0},
        {8'h36, 4'b1000, 7'd64, 1'b0, 1'b0, 1'b1},
        {8'h58, 4'b1010, 7'd1,  1'b1, 1'b0, 1'b0},
        {8'h7D, 4'b1011, 7'd16, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic [7:0] v);
        @(negedge clk);
        cs = 1; rw = 0; rs = sel; wdata = v;
        @(negedge clk);
        cs = 0; rw = 1;
    endtask

    task automatic bus_rd(input logic sel, output logic [7:0] v);
        @(negedge clk);
        cs = 1; rw = 1; rs = sel;
        #1 v = rdata;
        @(negedge clk);
        cs = 0;
    endtask

    task automatic load_rx(input logic [7:0] c, input logic pe, input logic fe);
        @(negedge clk);
        rx_load = 1; rx_char = c; rx_perr = pe; rx_ferr = fe;
        @(negedge clk);
        rx_load = 0; rx_perr = 0; rx_ferr = 0;
    endtask

    task automatic take_tx();
        @(negedge clk);
        tx_take = 1;
        @(negedge clk);
        tx_take = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2 R6 reset state: master reset
        bus_rd(0, v);
        chk("R2 reset status", v, 8'h00);
        chk("R2 reset irq_n", irq_n, 1);
        chk("R2 reset idle", dp_idle, 1);

        // R2 loads and data writes ignored in master reset
        load_rx(8'h11, 0, 0);
        bus_wr(1, 8'h99);
        chk("R2 write ignored", tx_pending, 0);
        bus_wr(0, 8'h15);
        chk("R2 leave reset", dp_idle, 0);
        bus_rd(0, v);
        chk("R2 load ignored", v, 8'h02);

        // R1 R3 R4 R10 table walk
        for (int i = 0; i < 8; i++) begin
            bus_wr(0, VEC[i][21:14]);
            chk("R3 format", {fmt_len8, fmt_stop2, fmt_par_en, fmt_par_odd}, VEC[i][13:10]);
            chk("R1 divisor", div_ratio, VEC[i][9:3]);
            chk("R4 rts", rts_line, VEC[i][2]);
            chk("R4 break", brk_out, VEC[i][1]);
            chk("R10 tx irq", !irq_n, VEC[i][0]);
        end

        bus_wr(0, 8'h15);
        // R9 cts masks empty
        cts_line = 1;
        bus_rd(0, v);
        chk("R9 cts high", v, 8'h08);
        cts_line = 0;
        // R6 carrier bit, no irq without rie
        dcd_line = 1;
        bus_rd(0, v);
        chk("R6 dcd bit", v, 8'h06);
        chk("R10 dcd masked", irq_n, 1);
        dcd_line = 0;

        // R7 no-parity format ignores parity error
        load_rx(8'hA5, 1, 1);
        bus_rd(0, v);
        chk("R7 status after load", v, 8'h13);
        bus_rd(1, v);
        chk("R7 data read", v, 8'hA5);
        bus_rd(0, v);
        chk("R7 cleared", v, 8'h02);

        // R5 R10 receive interrupt, 7E1
        bus_wr(0, 8'h89);
        load_rx(8'h3C, 1, 0);
        bus_rd(0, v);
        chk("R5 rx irq status", v, 8'hC3);
        chk("R10 irq_n low", irq_n, 0);
        // R8 overrun
        load_rx(8'h55, 0, 0);
        bus_rd(0, v);
        chk("R8 overrun status", v, 8'hE3);
        bus_rd(1, v);
        chk("R8 old char kept", v, 8'h3C);
        bus_rd(0, v);
        chk("R7 all cleared", v, 8'h02);
        chk("R10 irq released", irq_n, 1);
        // R10 carrier loss with rie
        dcd_line = 1;
        bus_rd(0, v);
        chk("R10 dcd irq", v, 8'h86);
        chk("R10 dcd irq_n", irq_n, 0);
        dcd_line = 0;

        // R11 transmit buffer
        bus_wr(1, 8'h77);
        chk("R11 pending", tx_pending, 1);
        chk("R11 data", tx_data, 8'h77);
        bus_rd(0, v);
        chk("R11 not empty", v, 8'h00);
        take_tx();
        chk("R11 taken", tx_pending, 0);
        bus_rd(0, v);
        chk("R11 empty again", v, 8'h02);

        // R10 transmit interrupt follows buffer
        bus_wr(0, 8'h35);
        chk("R10 tx irq on", irq_n, 0);
        bus_rd(0, v);
        chk("R10 status bit7", v, 8'h82);
        bus_wr(1, 8'h12);
        chk("R10 tx irq off", irq_n, 1);
        take_tx();

        // R2 master reset flushes pending flags
        load_rx(8'h66, 0, 1);
        bus_wr(0, 8'h03);
        bus_rd(0, v);
        chk("R2 mr status", v, 8'h00);
        chk("R2 mr idle", dp_idle, 1);
        chk("R2 mr divisor", div_ratio, 0);
        bus_wr(0, 8'h15);
        bus_rd(0, v);
        chk("R2 flushed", v, 8'h02);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule